// File: doc/BRIEF.md
# I2C Register Access Target

This block is the serial front door of a sensor-style device. It sits on a two-wire I2C bus as a target with a 7-bit address and gives an external host read and write access to a bank of 16-bit registers through a simple synchronous register-file port. The block runs on its own system clock and oversamples SCL and SDA. It drives SDA through an open-drain style enable: a high `sda_oe` pulls the line low. It never holds SCL.

In a write, the first byte after the address loads an 8-bit register pointer. Each later pair of bytes forms one 16-bit register value, sent high byte first, and is written to the register the pointer selects. To read, the host writes the pointer, issues a repeated START and sends the read address. The block then returns register contents high byte first and steps the pointer after each complete register. One select input chooses the low address bit. It is captured when the power controller raises the enable input. While the enable is low, the whole interface stays off the bus.

Top module: `i2c_regport`

## Requirements
- R1: After reset, `sda_oe` and `reg_wr` are low.
- R2: The block acknowledges (drives SDA low during the ninth clock) only the address 0x2A when the latched select is 0, or 0x2B when it is 1. It leaves any other address unacknowledged.
- R3: The select input is captured on the cycle the enable input rises. Later changes to the select input do not alter the address the block answers to.
- R4: While the enable input is low, the block acknowledges no address, keeps `sda_oe` low, issues no write, and clears the pointer to 0.
- R5: In a write transfer, the first byte after the address is acknowledged and loaded into the register pointer.
- R6: Each later pair of bytes, MSB first with the high byte first, produces a one-cycle `reg_wr` pulse. During the pulse `reg_addr` equals the pointer and `reg_wdata` holds the 16-bit value. The pointer then increments by 1.
- R7: A register left with only its high byte received when a STOP or repeated START arrives is not written.
- R8: After a repeated START with the read address, the block sends the register at the pointer, MSB first and high byte first. It increments the pointer after each complete register, so an acknowledged low byte is followed by the next register.
- R9: When the host does not acknowledge a read byte, the block releases SDA and stays silent until the next START. A register read only in part does not advance the pointer.
- R10: The block changes `sda_oe` only while SCL is low, and it operates at a 400 kbit/s bus rate with a 100 MHz system clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable from the power controller; low means shutdown |
| addr_sel | input | 1 | Chooses the low address bit; captured when `en` rises |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| sda_oe | output | 1 | High pulls SDA low; low releases it |
| reg_addr | output | 8 | Register pointer presented to the register file |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 16 | Value to write when `reg_wr` is high |
| reg_rdata | input | 16 | Register file contents at `reg_addr` (combinational) |

## Verification
The bench moves the select input while the block is enabled and after a shutdown. A design that samples the pin continuously would then answer the wrong address. It stops a write after one data byte, which catches a design that commits half a register. It NACKs the high byte of a read and then clocks the bus without a START; a design that stays engaged would drive SDA or advance the pointer. It also reads across a register boundary at the 400 kbit/s rate, where a late pointer step or a stale prefetch returns the previous register.

// File: rtl/i2c_regport.sv
module i2c_regport #(
  parameter logic [6:0] BASE_ADDR = 7'h2A,
  parameter int         RW        = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          addr_sel,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [7:0]    reg_addr,
  output logic          reg_wr,
  output logic [RW-1:0] reg_wdata,
  input  logic [RW-1:0] reg_rdata
);
  localparam int NB = RW / 8;
  localparam int BW = (NB > 1) ? $clog2(NB) : 1;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_PTR, S_WR, S_RD} st_t;

  st_t           st;
  logic [2:0]    scl_q, sda_q;
  logic          sel_l, en_q, ackph, full, rw, nack;
  logic [2:0]    cnt;
  logic [7:0]    sr, ptr;
  logic [BW-1:0] bidx;
  logic [RW-1:0] tx, wbuf;

  wire scl      = scl_q[1];
  wire sda      = sda_q[1];
  wire scl_rise = scl & ~scl_q[2];
  wire scl_fall = ~scl & scl_q[2];
  wire start    = scl & scl_q[2] & ~sda & sda_q[2];
  wire stop     = scl & scl_q[2] & sda & ~sda_q[2];
  wire addr_hit = (sr[7:1] == {BASE_ADDR[6:1], sel_l});
  wire last_b   = (bidx == BW'(NB - 1));

  assign reg_addr = ptr;

  // two synchronizer stages plus one history stage for edge detection
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_l <= 1'b0;
    end else begin
      en_q <= en;
      if (en && !en_q) sel_l <= addr_sel;
    end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sda_oe    <= 1'b0;
      reg_wr    <= 1'b0;
      reg_wdata <= '0;
      ackph     <= 1'b0;
      full      <= 1'b0;
      rw        <= 1'b0;
      nack      <= 1'b0;
      cnt       <= '0;
      sr        <= '0;
      ptr       <= '0;
      bidx      <= '0;
      tx        <= '0;
      wbuf      <= '0;
    end else begin
      reg_wr <= 1'b0;
      if (reg_wr) ptr <= ptr + 8'd1;
      if (!en) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
        ptr    <= '0;
        ackph  <= 1'b0;
        full   <= 1'b0;
      end else if (start) begin
        st     <= S_ADDR;
        sda_oe <= 1'b0;
        cnt    <= '0;
        ackph  <= 1'b0;
        full   <= 1'b0;
        bidx   <= '0;
      end else if (stop) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
        ackph  <= 1'b0;
        full   <= 1'b0;
      end else if (st != S_IDLE) begin
        if (!ackph && st != S_RD) begin
          if (scl_rise) begin
            sr  <= {sr[6:0], sda};
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) full <= 1'b1;
          end else if (scl_fall && full) begin
            full   <= 1'b0;
            ackph  <= 1'b1;
            sda_oe <= 1'b1;
            case (st)
              S_ADDR:
                if (!addr_hit) begin
                  st     <= S_IDLE;
                  sda_oe <= 1'b0;
                  ackph  <= 1'b0;
                end else begin
                  rw   <= sr[0];
                  tx   <= reg_rdata;
                  bidx <= '0;
                end
              S_PTR: begin
                ptr  <= sr;
                bidx <= '0;
              end
              S_WR:
                if (last_b) begin
                  reg_wr    <= 1'b1;
                  reg_wdata <= {wbuf[RW-9:0], sr};
                  bidx      <= '0;
                end else begin
                  wbuf <= {wbuf[RW-9:0], sr};
                  bidx <= bidx + 1'b1;
                end
              default: ;
            endcase
          end
        end else if (ackph && st != S_RD) begin
          if (scl_fall) begin
            ackph  <= 1'b0;
            cnt    <= '0;
            sda_oe <= 1'b0;
            case (st)
              S_ADDR:
                if (rw) begin
                  st     <= S_RD;
                  sda_oe <= ~tx[RW-1];
                end else begin
                  st <= S_PTR;
                end
              S_PTR:   st <= S_WR;
              default: ;
            endcase
          end
        end else if (!ackph) begin
          if (scl_fall) begin
            tx <= tx << 1;
            if (cnt == 3'd7) begin
              sda_oe <= 1'b0;
              ackph  <= 1'b1;
              nack   <= 1'b0;
              cnt    <= '0;
              if (last_b) ptr <= ptr + 8'd1;
            end else begin
              sda_oe <= ~tx[RW-2];
              cnt    <= cnt + 3'd1;
            end
          end
        end else begin
          if (scl_rise) begin
            nack <= sda;
            if (!sda && last_b) tx <= reg_rdata;
          end else if (scl_fall) begin
            ackph <= 1'b0;
            if (nack) begin
              st <= S_IDLE;
            end else begin
              sda_oe <= ~tx[RW-1];
              bidx   <= last_b ? '0 : bidx + 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       reg_wr,
  input logic [7:0] reg_addr
);
  AST_OFF_SILENT:   assert property (@(posedge clk) disable iff (!rst_n) !en |=> !sda_oe); // R4
  AST_OFF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !reg_wr); // R4
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |=> !reg_wr); // R6
  AST_PTR_STEP:     assert property (@(posedge clk) disable iff (!rst_n) (reg_wr && en) |=> reg_addr == $past(reg_addr) + 8'd1); // R6
  AST_SDA_SCL_LOW:  assert property (@(posedge clk) disable iff (!rst_n) (en && $past(en) && !$stable(sda_oe)) |-> !scl_i); // R10
endmodule

bind i2c_regport i2c_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .scl_i(scl_i),
  .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_addr(reg_addr)
);

// File: tb/i2c_regport_test.sv
module i2c_regport_test;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, addr_sel = 1'b0;
  logic scl = 1'b1, m_low = 1'b0;
  logic sda_oe, reg_wr;
  logic [7:0] reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic [15:0] mem [256];
  wire sda_line = !(sda_oe || m_low);
  int vecs = 0, errs = 0, wr_cnt = 0, q = 10, bad_oe = 0;
  logic [7:0] last_wa;
  logic prev_oe = 1'b0;

  always #5 clk = ~clk;

  i2c_regport uut (
    .clk(clk), .rst_n(rst_n), .en(en), .addr_sel(addr_sel),
    .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) if (reg_wr) begin
    mem[reg_addr] <= reg_wdata;
    last_wa <= reg_addr;
    wr_cnt <= wr_cnt + 1;
  end

  // R10: the target may only move SDA while the bus clock is low
  always @(negedge clk) begin
    if (rst_n && en && sda_oe != prev_oe && scl) bad_oe <= bad_oe + 1;
    prev_oe <= sda_oe;
  end

  task automatic chk(input string rq, input string what, input int act, input int exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic hold(); repeat (q) @(negedge clk); endtask
  task automatic bstart(); m_low = 0; hold(); scl = 1; hold(); m_low = 1; hold(); scl = 0; hold(); endtask
  task automatic bstop(); m_low = 1; hold(); scl = 1; hold(); m_low = 0; hold(); endtask
  task automatic wbit(input bit b, output bit s);
    m_low = !b; hold(); scl = 1; hold(); s = sda_line; hold(); scl = 0; hold();
  endtask
  task automatic wbyte(input logic [7:0] d, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) wbit(d[i], s);
    wbit(1'b1, s);
    ack = !s;
  endtask
  task automatic rbyte(input bit ack, output logic [7:0] d);
    bit s;
    for (int i = 7; i >= 0; i--) begin wbit(1'b1, s); d[i] = s; end
    wbit(!ack, s);
  endtask
  task automatic probe(input logic [6:0] a, output bit ack);
    bstart(); wbyte({a, 1'b0}, ack); bstop();
  endtask

  task automatic t_reset();
    chk("R1", "sda_oe after reset", sda_oe, 0);
    chk("R1", "reg_wr after reset", reg_wr, 0);
  endtask

  task automatic t_addr();
    bit a;
    probe(7'h2A, a); chk("R2", "ack 0x2A sel0", a, 1);
    probe(7'h2B, a); chk("R2", "ack 0x2B sel0", a, 0);
    probe(7'h15, a); chk("R2", "ack 0x15", a, 0);
  endtask

  task automatic t_write();
    bit a; int w0 = wr_cnt;
    bstart();
    wbyte(8'h54, a); chk("R2", "write addr ack", a, 1);
    wbyte(8'h10, a); chk("R5", "pointer ack", a, 1);
    wbyte(8'hBE, a); chk("R6", "data ack", a, 1);
    wbyte(8'hEF, a);
    wbyte(8'h12, a);
    wbyte(8'h34, a); chk("R6", "data ack last", a, 1);
    bstop();
    chk("R6", "mem[10]", mem[8'h10], 16'hBEEF);
    chk("R6", "mem[11]", mem[8'h11], 16'h1234);
    chk("R6", "write count", wr_cnt - w0, 2);
    chk("R6", "last write addr", last_wa, 8'h11);
  endtask

  task automatic t_partial();
    bit a; int w0;
    mem[8'h20] = 16'hAAAA;
    w0 = wr_cnt;
    bstart(); wbyte(8'h54, a); wbyte(8'h20, a); wbyte(8'h55, a); bstop();
    bstart(); wbyte(8'h54, a); wbyte(8'h20, a); wbyte(8'h66, a);
    bstart(); wbyte(8'h55, a); bstop();
    chk("R7", "no write on half register", wr_cnt - w0, 0);
    chk("R7", "mem[20] kept", mem[8'h20], 16'hAAAA);
  endtask

  task automatic t_read(input logic [7:0] p);
    bit a; logic [7:0] d;
    mem[p] = 16'h1357; mem[p + 8'd1] = 16'h9ACE;
    bstart(); wbyte(8'h54, a); wbyte(p, a);
    bstart(); wbyte(8'h55, a); chk("R8", "read addr ack", a, 1);
    rbyte(1'b1, d); chk("R8", "byte0", d, 8'h13);
    rbyte(1'b1, d); chk("R8", "byte1", d, 8'h57);
    rbyte(1'b1, d); chk("R8", "byte2 next reg", d, 8'h9A);
    rbyte(1'b0, d); chk("R8", "byte3", d, 8'hCE);
    bstop();
    chk("R10", "sda released at end", sda_oe, 0);
  endtask

  task automatic t_nack();
    bit a, s; logic [7:0] d; int low = 0;
    mem[8'h40] = 16'hF00F;
    bstart(); wbyte(8'h54, a); wbyte(8'h40, a);
    bstart(); wbyte(8'h55, a); rbyte(1'b0, d);
    chk("R9", "high byte", d, 8'hF0);
    for (int i = 0; i < 9; i++) begin wbit(1'b1, s); if (!s) low++; end
    chk("R9", "silent after nack", low, 0);
    bstop();
    bstart(); wbyte(8'h55, a); rbyte(1'b0, d); bstop();
    chk("R9", "pointer kept after partial read", d, 8'hF0);
  endtask

  task automatic t_sel();
    bit a;
    addr_sel = 1'b1; hold();
    probe(7'h2A, a); chk("R3", "0x2A after live pin change", a, 1);
    probe(7'h2B, a); chk("R3", "0x2B after live pin change", a, 0);
  endtask

  task automatic t_shutdown();
    bit a; logic [7:0] d;
    mem[8'h00] = 16'h0C0D;
    en = 1'b0; hold();
    probe(7'h2A, a); chk("R4", "0x2A while off", a, 0);
    probe(7'h2B, a); chk("R4", "0x2B while off", a, 0);
    en = 1'b1; hold();
    probe(7'h2B, a); chk("R3", "0x2B after enable sel1", a, 1);
    probe(7'h2A, a); chk("R3", "0x2A after enable sel1", a, 0);
    addr_sel = 1'b0; hold();
    probe(7'h2B, a); chk("R3", "0x2B after pin low", a, 1);
    bstart(); wbyte(8'h57, a); rbyte(1'b0, d); bstop();
    chk("R4", "pointer cleared by shutdown", d, 8'h0C);
  endtask

  task automatic t_fast();
    bit a; logic [7:0] d;
    q = 63;
    bstart(); wbyte(8'h56, a); wbyte(8'h50, a);
    wbyte(8'hC3, a); wbyte(8'h5A, a); bstop();
    chk("R10", "400k write", mem[8'h50], 16'hC35A);
    bstart(); wbyte(8'h56, a); wbyte(8'h50, a);
    bstart(); wbyte(8'h57, a); rbyte(1'b1, d);
    chk("R10", "400k read hi", d, 8'hC3);
    rbyte(1'b0, d); bstop();
    chk("R10", "400k read lo", d, 8'h5A);
    q = 10;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    en = 1'b1;
    repeat (4) @(negedge clk);
    t_addr();
    t_write();
    t_partial();
    t_read(8'h30);
    t_read(8'hFE);
    t_nack();
    t_sel();
    t_shutdown();
    t_fast();
    chk("R10", "sda moves while scl high", bad_oe, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule